// File: doc/BRIEF.md
# Start/Stop Serial Character Receiver with Break Detection

The block turns a start/stop serial line into characters. The line is sampled on a qualifying tick from an external rate source. Each tick stands for one bit in 1X mode and for one sixteenth of a bit in 16X mode. A frame is a low start bit, 5 to 8 data bits sent least significant bit first, an optional parity bit and a high stop bit. Each completed character is offered to a downstream FIFO as a single-cycle push. The push carries the right-aligned data and a status word.

The receiver checks parity, framing and overrun. In 16X mode it discards start bits that do not last to mid-bit. After a framing error it waits half a bit before it hunts again. A received break raises one event when it is seen and a second event when the line returns to mark. Each character is also compared with a programmed value. An optional active-low carrier-detect input can hold the receiver idle.

Top module: `async_rx`

## Requirements
- R1: `cfg_len_i` selects the character length: 0=5, 1=6, 2=7, 3=8 bits. The first data bit received becomes bit 0 of `push_data_o`. Bits at and above the character length are zero.
- R2: `cfg_par_i` selects parity: 0 none, 1 even, 2 odd, 3 forced low, 4 forced high, and 5 to 7 none. With parity active, a received parity bit that differs from the expected value sets status bit 0. With parity off, no parity bit is expected and status bit 0 stays clear.
- R3: In 1X mode (`cfg_x16_i`=0), the first tick that samples the line low is taken as the start bit. Each following tick samples one further bit.
- R4: In 16X mode, a low sample starts a start-bit check. The line is sampled again 8 ticks later. If it is high, the start is dropped and nothing is pushed. Otherwise each later bit is sampled every 16 ticks.
- R5: A stop bit sampled low on a character that is not a break pushes the character with status bit 1 set. In 16X mode, hunting for the next start bit resumes 8 ticks after that stop sample.
- R6: A break is a character whose data bits, parity bit (if any) and stop bit are all low. It is pushed with data 0 and status bits 4 and 1 set. `brk_start_o` pulses for one cycle. No further character is taken until a tick samples the line high. That tick causes a one-cycle `brk_end_o` pulse.
- R7: Status bit 3 is set when the data equals `cfg_match_i` masked to the character length. A break never sets it.
- R8: A character completed while `full_i` is high is not pushed. The next pushed character carries status bit 2 set.
- R9: With `cfg_cd_en_i` high and `cd_ni` high, the receiver is held idle and pushes nothing. With `cfg_cd_en_i` low, `cd_ni` has no effect.
- R10: After reset `push_o`, `brk_start_o` and `brk_end_o` are low. `push_o` is high for one cycle per character, in the cycle after the stop-bit sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Sample qualifier from the rate source |
| rx_i | input | 1 | Serial line, idle high |
| cd_ni | input | 1 | Carrier detect, active low |
| cfg_cd_en_i | input | 1 | Enables carrier-detect gating |
| cfg_x16_i | input | 1 | 1 = 16X oversampling, 0 = 1X |
| cfg_len_i | input | 2 | Character length code |
| cfg_par_i | input | 3 | Parity mode code |
| cfg_match_i | input | 8 | Comparison character |
| full_i | input | 1 | Downstream FIFO full |
| push_o | output | 1 | Character push strobe |
| push_data_o | output | 8 | Received character, right-aligned |
| push_stat_o | output | 5 | {break, match, overrun, framing, parity} |
| brk_start_o | output | 1 | Break detected pulse |
| brk_end_o | output | 1 | Break ended pulse |

## Verification
The hardest case to reach is the half-bit wait after a framing error. A receiver that hunts again at once and one that waits often decode the same thing. They differ only when the line stays low a few ticks past the bad stop bit and then returns high. The bench sends a framing-error character, keeps the line low for four more ticks and then holds it at mark. A correct receiver then sees a false start and pushes nothing more. A receiver that hunted too early confirms a start bit and pushes a spurious character. The break path is reached the same way: the line is held low through the stop bit and well beyond, and the events are counted before and after the line returns high.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;

  typedef enum logic [2:0] {
    PAR_NONE  = 3'd0,
    PAR_EVEN  = 3'd1,
    PAR_ODD   = 3'd2,
    PAR_SPACE = 3'd3,
    PAR_MARK  = 3'd4
  } par_mode_e;

  typedef struct packed {
    logic brk;
    logic match;
    logic ovr;
    logic frm;
    logic par;
  } rx_stat_t;

  localparam int STAT_W = $bits(rx_stat_t);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_REHUNT,
    ST_BRK
  } rx_state_e;

  function automatic logic par_active(input logic [2:0] code);
    return (code >= 3'd1) && (code <= 3'd4);
  endfunction

endpackage

// File: rtl/async_rx_sync.sv
module async_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  input  logic cd_ni,
  input  logic cd_en_i,
  output logic rx_o,
  output logic line_ok_o
);

  logic [STAGES-1:0] rx_q, cd_q;

  if (STAGES == 1) begin : g_single
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rx_q <= '1;
        cd_q <= '1;
      end else begin
        rx_q <= STAGES'(rx_i);
        cd_q <= STAGES'(cd_ni);
      end
    end
  end else begin : g_chain
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rx_q <= '1;
        cd_q <= '1;
      end else begin
        rx_q <= {rx_q[STAGES-2:0], rx_i};
        cd_q <= {cd_q[STAGES-2:0], cd_ni};
      end
    end
  end

  assign rx_o      = rx_q[STAGES-1];
  assign line_ok_o = !cd_en_i || !cd_q[STAGES-1];

endmodule

// File: rtl/async_rx_eval.sv
module async_rx_eval
  import async_rx_pkg::*;
#(
  parameter int MIN_BITS = 5,
  parameter int MAX_BITS = 8,
  parameter int LEN_W    = 2
) (
  input  logic [MAX_BITS-1:0] shreg_i,
  input  logic [LEN_W-1:0]    len_i,
  input  logic [2:0]          par_mode_i,
  input  logic                par_bit_i,
  input  logic                stop_bit_i,
  input  logic [MAX_BITS-1:0] match_i,
  output logic [MAX_BITS-1:0] data_o,
  output logic                par_err_o,
  output logic                frm_err_o,
  output logic                brk_o,
  output logic                match_o
);

  int                  nbits;
  logic [MAX_BITS-1:0] mask;
  logic                par_exp;
  logic                par_on;

  always_comb begin
    nbits  = MIN_BITS + int'(len_i);
    data_o = shreg_i >> (MAX_BITS - nbits);
    for (int i = 0; i < MAX_BITS; i++) mask[i] = (i < nbits);

    par_on = par_active(par_mode_i);
    unique case (par_mode_i)
      PAR_EVEN:  par_exp = ^data_o;
      PAR_ODD:   par_exp = ~^data_o;
      PAR_MARK:  par_exp = 1'b1;
      default:   par_exp = 1'b0;
    endcase

    brk_o     = (data_o == '0) && !(par_on && par_bit_i) && !stop_bit_i;
    frm_err_o = !stop_bit_i;
    par_err_o = par_on && (par_bit_i != par_exp) && !brk_o;
    match_o   = !brk_o && (data_o == (match_i & mask));
  end

endmodule

// File: rtl/async_rx_fsm.sv
module async_rx_fsm
  import async_rx_pkg::*;
#(
  parameter int OSR      = 16,
  parameter int MIN_BITS = 5,
  parameter int MAX_BITS = 8,
  parameter int LEN_W    = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                x16_i,
  input  logic [LEN_W-1:0]    len_i,
  input  logic                par_en_i,
  input  logic                rx_i,
  input  logic                line_ok_i,
  input  logic                brk_i,
  input  logic                frm_i,
  output logic [MAX_BITS-1:0] shreg_o,
  output logic                par_bit_o,
  output logic                done_o,
  output logic                brk_end_o
);

  localparam int CNT_W = $clog2(OSR);
  localparam int BIT_W = $clog2(MAX_BITS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OSR - 1);
  localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(OSR / 2 - 1);

  rx_state_e           state_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [BIT_W-1:0]    bit_q;
  logic [MAX_BITS-1:0] shreg_q;
  logic                par_q;
  logic                phase_end;
  logic [BIT_W-1:0]    last_bit;
  logic                step;

  assign phase_end = !x16_i || (cnt_q == CNT_LAST);
  assign last_bit  = BIT_W'(MIN_BITS - 1) + BIT_W'(len_i);
  assign step      = tick_i && line_ok_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      shreg_q <= '0;
      par_q   <= 1'b0;
    end else if (!line_ok_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (tick_i) begin
      unique case (state_q)
        ST_IDLE: if (!rx_i) begin
          cnt_q   <= '0;
          bit_q   <= '0;
          state_q <= x16_i ? ST_START : ST_DATA;
        end
        ST_START: if (cnt_q == CNT_HALF) begin
          cnt_q   <= '0;
          state_q <= rx_i ? ST_IDLE : ST_DATA;
        end else cnt_q <= cnt_q + 1'b1;
        ST_DATA: if (phase_end) begin
          cnt_q   <= '0;
          shreg_q <= {rx_i, shreg_q[MAX_BITS-1:1]};
          if (bit_q == last_bit) state_q <= par_en_i ? ST_PAR : ST_STOP;
          else                   bit_q   <= bit_q + 1'b1;
        end else cnt_q <= cnt_q + 1'b1;
        ST_PAR: if (phase_end) begin
          cnt_q   <= '0;
          par_q   <= rx_i;
          state_q <= ST_STOP;
        end else cnt_q <= cnt_q + 1'b1;
        ST_STOP: if (phase_end) begin
          cnt_q <= '0;
          if (brk_i)               state_q <= ST_BRK;
          else if (frm_i && x16_i) state_q <= ST_REHUNT;
          else                     state_q <= ST_IDLE;
        end else cnt_q <= cnt_q + 1'b1;
        ST_REHUNT: if (cnt_q == CNT_HALF) begin
          cnt_q   <= '0;
          state_q <= ST_IDLE;
        end else cnt_q <= cnt_q + 1'b1;
        ST_BRK: if (rx_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign shreg_o   = shreg_q;
  assign par_bit_o = par_q;
  assign done_o    = step && (state_q == ST_STOP) && phase_end;
  assign brk_end_o = step && (state_q == ST_BRK) && rx_i;

endmodule

// File: rtl/async_rx.sv
module async_rx
  import async_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_BITS    = 5,
  parameter int MAX_BITS    = 8,
  parameter int LEN_W       = $clog2(MAX_BITS - MIN_BITS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                rx_i,
  input  logic                cd_ni,
  input  logic                cfg_cd_en_i,
  input  logic                cfg_x16_i,
  input  logic [LEN_W-1:0]    cfg_len_i,
  input  logic [2:0]          cfg_par_i,
  input  logic [MAX_BITS-1:0] cfg_match_i,
  input  logic                full_i,
  output logic                push_o,
  output logic [MAX_BITS-1:0] push_data_o,
  output logic [STAT_W-1:0]   push_stat_o,
  output logic                brk_start_o,
  output logic                brk_end_o
);

  logic                rx_s, line_ok;
  logic [MAX_BITS-1:0] shreg, ev_data;
  logic                par_bit, done, brk_end_ev;
  logic                ev_par, ev_frm, ev_brk, ev_match;

  async_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rx_i      (rx_i),
    .cd_ni     (cd_ni),
    .cd_en_i   (cfg_cd_en_i),
    .rx_o      (rx_s),
    .line_ok_o (line_ok)
  );

  async_rx_fsm #(
    .OSR(OSR), .MIN_BITS(MIN_BITS), .MAX_BITS(MAX_BITS), .LEN_W(LEN_W)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .x16_i     (cfg_x16_i),
    .len_i     (cfg_len_i),
    .par_en_i  (par_active(cfg_par_i)),
    .rx_i      (rx_s),
    .line_ok_i (line_ok),
    .brk_i     (ev_brk),
    .frm_i     (ev_frm),
    .shreg_o   (shreg),
    .par_bit_o (par_bit),
    .done_o    (done),
    .brk_end_o (brk_end_ev)
  );

  async_rx_eval #(
    .MIN_BITS(MIN_BITS), .MAX_BITS(MAX_BITS), .LEN_W(LEN_W)
  ) u_eval (
    .shreg_i    (shreg),
    .len_i      (cfg_len_i),
    .par_mode_i (cfg_par_i),
    .par_bit_i  (par_bit),
    .stop_bit_i (rx_s),
    .match_i    (cfg_match_i),
    .data_o     (ev_data),
    .par_err_o  (ev_par),
    .frm_err_o  (ev_frm),
    .brk_o      (ev_brk),
    .match_o    (ev_match)
  );

  logic                push_q, ovr_pend_q, brk_s_q, brk_e_q;
  logic [MAX_BITS-1:0] data_q;
  rx_stat_t            stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      push_q     <= 1'b0;
      data_q     <= '0;
      stat_q     <= '0;
      ovr_pend_q <= 1'b0;
      brk_s_q    <= 1'b0;
      brk_e_q    <= 1'b0;
    end else begin
      push_q  <= 1'b0;
      brk_s_q <= done && ev_brk;
      brk_e_q <= brk_end_ev;
      if (done) begin
        if (full_i) begin
          ovr_pend_q <= 1'b1;
        end else begin
          push_q     <= 1'b1;
          data_q     <= ev_data;
          stat_q     <= '{brk: ev_brk, match: ev_match, ovr: ovr_pend_q,
                          frm: ev_frm, par: ev_par};
          ovr_pend_q <= 1'b0;
        end
      end
    end
  end

  assign push_o      = push_q;
  assign push_data_o = data_q;
  assign push_stat_o = stat_q;
  assign brk_start_o = brk_s_q;
  assign brk_end_o   = brk_e_q;

endmodule

// File: rtl/async_rx_chk.sv
module async_rx_chk #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_BITS    = 5,
  parameter int MAX_BITS    = 8,
  parameter int LEN_W       = 2,
  parameter int STAT_W      = 5
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                cd_ni,
  input logic                cfg_cd_en_i,
  input logic [LEN_W-1:0]    cfg_len_i,
  input logic [2:0]          cfg_par_i,
  input logic                full_i,
  input logic                push_o,
  input logic [MAX_BITS-1:0] push_data_o,
  input logic [STAT_W-1:0]   push_stat_o,
  input logic                brk_start_o,
  input logic                brk_end_o
);

  localparam int GATE_LAT = SYNC_STAGES + 3;
  localparam int GCW      = $clog2(GATE_LAT + 1) + 1;

  logic           in_brk_q;
  logic [GCW-1:0] gate_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_brk_q   <= 1'b0;
      gate_cnt_q <= '0;
    end else begin
      if (brk_start_o)    in_brk_q <= 1'b1;
      else if (brk_end_o) in_brk_q <= 1'b0;
      if (!(cfg_cd_en_i && cd_ni))           gate_cnt_q <= '0;
      else if (gate_cnt_q != GCW'(GATE_LAT)) gate_cnt_q <= gate_cnt_q + 1'b1;
    end
  end

  assert_push_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |=> !push_o);

  assert_no_push_full_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> !$past(full_i));

  assert_par_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_o && cfg_par_i == 3'd0) |-> !push_stat_o[0]);

  assert_brk_shape_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_o && push_stat_o[4]) |-> (push_data_o == '0 && push_stat_o[1] && !push_stat_o[3]));

  assert_brk_end_after_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_end_o |-> in_brk_q);

  assert_brk_start_once_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_start_o |-> !in_brk_q);

  assert_cd_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_cnt_q == GCW'(GATE_LAT)) |-> !push_o);

  assert_data_width_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> ((push_data_o >> (MIN_BITS + int'(cfg_len_i))) == '0));

endmodule

bind async_rx async_rx_chk #(
  .SYNC_STAGES(SYNC_STAGES), .MIN_BITS(MIN_BITS), .MAX_BITS(MAX_BITS),
  .LEN_W(LEN_W), .STAT_W(async_rx_pkg::STAT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cd_ni       (cd_ni),
  .cfg_cd_en_i (cfg_cd_en_i),
  .cfg_len_i   (cfg_len_i),
  .cfg_par_i   (cfg_par_i),
  .full_i      (full_i),
  .push_o      (push_o),
  .push_data_o (push_data_o),
  .push_stat_o (push_stat_o),
  .brk_start_o (brk_start_o),
  .brk_end_o   (brk_end_o)
);

// File: tb/async_rx_tb.sv
module async_rx_tb;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick = 1'b0;
  logic       rx = 1'b1;
  logic       cd_n = 1'b1;
  logic       cd_en = 1'b0;
  logic       x16 = 1'b1;
  logic       full = 1'b0;
  logic [1:0] len = 2'd3;
  logic [2:0] par = 3'd0;
  logic [7:0] mval = 8'h3C;

  logic       push, bs, be;
  logic [7:0] pdata;
  logic [4:0] pstat;

  async_rx u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .rx_i(rx), .cd_ni(cd_n),
    .cfg_cd_en_i(cd_en), .cfg_x16_i(x16), .cfg_len_i(len), .cfg_par_i(par),
    .cfg_match_i(mval), .full_i(full), .push_o(push), .push_data_o(pdata),
    .push_stat_o(pstat), .brk_start_o(bs), .brk_end_o(be)
  );

  always #5 clk = ~clk;

  int div = 0;
  always @(negedge clk) begin
    if (div == 3) begin div <= 0; tick <= 1'b1; end
    else begin div <= div + 1; tick <= 1'b0; end
  end

  int n_push = 0, n_bs = 0, n_be = 0;
  logic [7:0] last_d = '0;
  logic [4:0] last_s = '0;
  always @(negedge clk) begin
    if (push) begin n_push <= n_push + 1; last_d <= pdata; last_s <= pstat; end
    if (bs) n_bs <= n_bs + 1;
    if (be) n_be <= n_be + 1;
  end

  int n_chk = 0, n_fail = 0;
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL R10 watchdog: actual %0d expected below 150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic wait_tick();
    @(posedge clk);
    while (!tick) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input logic v, input int n);
    rx = v;
    repeat (n) wait_tick();
  endtask

  task automatic send(input logic fx16, input logic [1:0] flen, input logic [2:0] fpar,
                      input logic [7:0] d, input logic bad, input logic stopv);
    int   tpb;
    logic pb;
    x16 = fx16; len = flen; par = fpar;
    tpb = fx16 ? 16 : 1;
    drive(1'b0, tpb);
    for (int i = 0; i < 5 + int'(flen); i++) drive(d[i], tpb);
    if (fpar >= 3'd1 && fpar <= 3'd4) begin
      case (fpar)
        3'd1:    pb = ^d;
        3'd2:    pb = ~^d;
        3'd3:    pb = 1'b0;
        default: pb = 1'b1;
      endcase
      drive(pb ^ bad, tpb);
    end
    drive(stopv, tpb);
    if (stopv) drive(1'b1, 2 * tpb);
  endtask

  // {x16, len, par, data, bad parity, expected status}
  localparam int NV = 11;
  localparam logic [19:0] VEC [NV] = '{
    {1'b1, 2'd3, 3'd0, 8'hA5, 1'b0, 5'h00},
    {1'b1, 2'd2, 3'd1, 8'h53, 1'b0, 5'h00},
    {1'b1, 2'd0, 3'd2, 8'h1F, 1'b0, 5'h00},
    {1'b1, 2'd1, 3'd1, 8'h2A, 1'b1, 5'h01},
    {1'b0, 2'd3, 3'd2, 8'h3C, 1'b0, 5'h08},
    {1'b0, 2'd0, 3'd4, 8'h15, 1'b0, 5'h00},
    {1'b0, 2'd3, 3'd3, 8'h80, 1'b1, 5'h01},
    {1'b1, 2'd1, 3'd0, 8'h3C, 1'b0, 5'h08},
    {1'b1, 2'd3, 3'd4, 8'hFF, 1'b0, 5'h00},
    {1'b0, 2'd2, 3'd1, 8'h7F, 1'b1, 5'h01},
    {1'b1, 2'd0, 3'd0, 8'h1C, 1'b0, 5'h08}
  };

  initial begin
    int base;
    repeat (3) @(negedge clk);
    chk("R10 push after reset", push, 0);
    chk("R10 brk_start after reset", bs, 0);
    chk("R10 brk_end after reset", be, 0);
    rst_ni = 1'b1;
    drive(1'b1, 8);

    for (int k = 0; k < NV; k++) begin
      logic [19:0] v;
      v = VEC[k];
      base = n_push;
      send(v[19], v[18:17], v[16:14], v[13:6], v[5], 1'b1);
      chk(v[19] ? "R4 one push per frame" : "R3 one push per frame", n_push - base, 1);
      chk("R1 data", last_d, v[13:6]);
      chk(v[4:0] == 5'h08 ? "R7 status" : "R2 status", last_s, v[4:0]);
    end

    // R4: start bit gone before its mid sample
    base = n_push;
    x16 = 1'b1;
    drive(1'b0, 5);
    drive(1'b1, 40);
    chk("R4 false start", n_push - base, 0);

    // R5: framing error, line low 4 ticks past the stop bit, then mark
    base = n_push;
    send(1'b1, 2'd3, 3'd0, 8'h41, 1'b0, 1'b0);
    drive(1'b0, 4);
    chk("R5 framing push", n_push - base, 1);
    chk("R5 framing data", last_d, 8'h41);
    chk("R5 framing status", last_s, 5'h02);
    drive(1'b1, 48);
    chk("R5 rehunt half bit later", n_push - base, 1);
    chk("R5 no break on framing", n_bs, 0);

    // R6: break with even parity, held low well past the stop bit
    base = n_push;
    send(1'b1, 2'd3, 3'd1, 8'h00, 1'b0, 1'b0);
    drive(1'b0, 20);
    chk("R6 break push", n_push - base, 1);
    chk("R6 break data", last_d, 8'h00);
    chk("R6 break status", last_s, 5'h12);
    chk("R6 break start", n_bs, 1);
    chk("R6 no end while low", n_be, 0);
    drive(1'b1, 4);
    chk("R6 break end", n_be, 1);
    chk("R6 single break start", n_bs, 1);
    drive(1'b1, 32);
    send(1'b1, 2'd3, 3'd0, 8'h5A, 1'b0, 1'b1);
    chk("R6 recovery data", last_d, 8'h5A);

    // R8: overrun
    base = n_push;
    full = 1'b1;
    send(1'b1, 2'd3, 3'd0, 8'h11, 1'b0, 1'b1);
    full = 1'b0;
    chk("R8 no push when full", n_push - base, 0);
    send(1'b1, 2'd3, 3'd0, 8'h22, 1'b0, 1'b1);
    chk("R8 next push", n_push - base, 1);
    chk("R8 next data", last_d, 8'h22);
    chk("R8 overrun status", last_s, 5'h04);

    // R9: carrier-detect gating
    cd_en = 1'b1;
    cd_n  = 1'b1;
    drive(1'b1, 4);
    base = n_push;
    send(1'b1, 2'd3, 3'd0, 8'h55, 1'b0, 1'b1);
    chk("R9 held idle", n_push - base, 0);
    cd_n = 1'b0;
    drive(1'b1, 4);
    send(1'b1, 2'd3, 3'd0, 8'h66, 1'b0, 1'b1);
    chk("R9 carrier present", last_d, 8'h66);
    cd_en = 1'b0;
    cd_n  = 1'b1;
    drive(1'b1, 4);
    send(1'b1, 2'd3, 3'd0, 8'h77, 1'b0, 1'b1);
    chk("R9 gating disabled", last_d, 8'h77);
    chk("R9 push count", n_push - base, 2);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule